// File: doc/BRIEF.md
# NAND Parallel Bus Cycle Engine

This block turns single accesses on a small register-style host port into byte-wide cycles on an 8-bit asynchronous NAND flash bus. The host port has three write targets: command, address and data. It also has a data read target and a status word. A command write drives one cycle with the command latch enable high. An address write drives one cycle with the address latch enable high. A data write drives a plain data-out cycle, and a data read drives a data-in cycle. A multi-byte address is sent as a run of single-byte address writes. The engine issues them on the bus in the order they were accepted.

Every phase of a cycle is a whole number of clock ticks. Each chip select has its own pair of packed 32-bit timing words, and the target picked by the access address supplies them. A field of zero counts as one tick. The flash ready/busy pin is synchronised into the clock domain. It is shown on a ready output and in the top bit of the status word. A host access that arrives while a cycle is running is held off by a wait output and is never lost.

Top module: `nbc_engine`

## Requirements
- R1: Address bits [9:8] pick the target; only that target's active-low chip enable goes low. Low byte 0x00 is a command cycle with CLE high, 0x04 is an address cycle with ALE high, and 0x08 is a data cycle with both latch enables low.
- R2: A write cycle runs in three phases. First WE# is low for wlo ticks, then high for m(wpw) ticks, with CLE/ALE and the driven data held through both phases. A final phase of m(extw) ticks follows with CE# still low, CLE/ALE low and the bus released. Here wlo = m(wc) − m(wpw), saturated at 1.
- R3: A data read runs in four phases, all with CE# low and the bus not driven. A setup phase of m(rdy) ticks has RE# high. RE# is then low for max(m(rpw), m(acc)) ticks. RE# goes high for m(hold) ticks, and a turnaround of m(extr) ticks follows.
- R4: Read data is the bus value at the clock edge that ends tick m(acc) of the RE#-low phase. It is returned zero-extended on h_rdata with a one-cycle h_rvalid in the first idle cycle after the turnaround.
- R5: m(x) is x, or 1 when x is 0. An all-zero timing pair therefore gives one-tick phases.
- R6: h_wait is high from the cycle after an accepted bus access until the last tick of that access. An access is accepted only when h_req is high and h_wait is low. A held request is issued later, and accepted bytes go out in acceptance order.
- R7: A read of low byte 0x0C returns, one cycle later, h_rvalid with bit 31 equal to the synchronised ready level and all other bits zero. It runs no flash cycle.
- R8: flash_rdy is nf_rb_n delayed by two clock edges, and it is 0 in reset.
- R9: Writes to any low byte other than 0x00, 0x04 or 0x08 are ignored: no flash cycle runs and h_wait stays low. Reads of any low byte other than 0x08 or 0x0C return 0 with h_rvalid one cycle later.
- R10: Timing word A packs fields most-significant first as rdy, extw, wc, wpw. Word B packs acc, hold, rpw, extr. Each is 8 bits, and target n uses bits [32n+31:32n] of each bus.
- R11: In reset and whenever idle, all CE# are high, WE# and RE# are high, CLE, ALE and the bus enable are low, and h_wait is low.
- R12: At most one CE# is low, CLE and ALE are never both high, and WE# and RE# are never both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one tick per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| h_req | input | 1 | Host access request |
| h_wr | input | 1 | 1 = write, 0 = read |
| h_addr | input | 10 | Target select [9:8], port offset [7:0] |
| h_wdata | input | 8 | Write byte |
| h_wait | output | 1 | Engine busy; request is held off |
| h_rdata | output | 32 | Read result |
| h_rvalid | output | 1 | h_rdata valid for this cycle |
| tim_wr_all | input | 128 | Per-target timing word A |
| tim_rd_all | input | 128 | Per-target timing word B |
| nf_ce_n | output | 4 | Active-low chip enables |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Active-low write strobe |
| nf_re_n | output | 1 | Active-low read strobe |
| nf_dq_out | output | 8 | Bus drive value |
| nf_dq_oe | output | 1 | Bus output enable |
| nf_dq_in | input | 8 | Bus sampled value |
| nf_rb_n | input | 1 | Flash ready/busy (1 = ready) |
| flash_rdy | output | 1 | Synchronised ready level |

## Verification
The assertions check the pin-level rules on every cycle. At most one chip enable is active, the latch enables and the strobes are never on together, and the bus is driven whenever WE# is low and never while RE# is low. An idle engine keeps every pin quiet, a read result never appears while busy, and an accepted command write raises the wait output. The lengths of each phase, the exact tick on which read data is sampled, the per-target timing choice, the saturating write-low length and the ready delay can only be shown by the bench's scenarios. The bench builds a cycle-by-cycle model of every output for each access it issues and compares it on each clock.

// File: rtl/nbc_pkg.sv
package nbc_pkg;

   localparam int unsigned NBC_FLD_W  = 8;
   localparam int unsigned NBC_TREG_W = 4 * NBC_FLD_W;

   typedef logic [NBC_FLD_W-1:0] nbc_tick_t;

   typedef enum logic [2:0] {
      NBC_PH_IDLE,
      NBC_PH_WLO,
      NBC_PH_WHI,
      NBC_PH_WEXT,
      NBC_PH_RSU,
      NBC_PH_RLO,
      NBC_PH_RHI,
      NBC_PH_RTRN
   } nbc_phase_e;

   typedef enum logic [1:0] {
      NBC_K_CMD,
      NBC_K_ADR,
      NBC_K_DAT
   } nbc_kind_e;

   // Phase lengths in ticks, every one at least 1
   typedef struct packed {
      nbc_tick_t wlo;
      nbc_tick_t whi;
      nbc_tick_t wext;
      nbc_tick_t rsu;
      nbc_tick_t rlo;
      nbc_tick_t rhi;
      nbc_tick_t rtrn;
      nbc_tick_t racc;
   } nbc_len_t;

   function automatic nbc_tick_t nbc_floor1(input nbc_tick_t v);
      return (v == '0) ? nbc_tick_t'(1) : v;
   endfunction

endpackage

// File: rtl/nbc_rdy_sync.sv
module nbc_rdy_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic sync_out
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("nbc_rdy_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] sr;

   always_ff @(posedge clk) begin
      if (!rst_n) sr <= '0;
      else        sr <= {sr[STAGES-2:0], async_in};
   end

   assign sync_out = sr[STAGES-1];

endmodule

// File: rtl/nbc_timing_sel.sv
module nbc_timing_sel
   import nbc_pkg::*;
#(
   parameter int unsigned NUM_CS = 4,
   localparam int unsigned CS_W  = $clog2(NUM_CS)
) (
   input  logic [NUM_CS*NBC_TREG_W-1:0] tim_wr_all,
   input  logic [NUM_CS*NBC_TREG_W-1:0] tim_rd_all,
   input  logic [CS_W-1:0]              sel,
   output nbc_len_t                     lens
);

   localparam int unsigned FW = NBC_FLD_W;
   localparam int unsigned RW = NBC_TREG_W;

   logic [RW-1:0] wr_arr [NUM_CS];
   logic [RW-1:0] rd_arr [NUM_CS];

   genvar g;
   generate
      for (g = 0; g < NUM_CS; g++) begin : g_unpack
         assign wr_arr[g] = tim_wr_all[g*RW +: RW];
         assign rd_arr[g] = tim_rd_all[g*RW +: RW];
      end
   endgenerate

   logic [RW-1:0] wr_w, rd_w;
   nbc_tick_t     rdy1, extw1, wc1, wpw1, acc1, hold1, rpw1, extr1;

   assign wr_w = wr_arr[sel];
   assign rd_w = rd_arr[sel];

   always_comb begin
      rdy1  = nbc_floor1(wr_w[3*FW +: FW]);
      extw1 = nbc_floor1(wr_w[2*FW +: FW]);
      wc1   = nbc_floor1(wr_w[1*FW +: FW]);
      wpw1  = nbc_floor1(wr_w[0*FW +: FW]);
      acc1  = nbc_floor1(rd_w[3*FW +: FW]);
      hold1 = nbc_floor1(rd_w[2*FW +: FW]);
      rpw1  = nbc_floor1(rd_w[1*FW +: FW]);
      extr1 = nbc_floor1(rd_w[0*FW +: FW]);

      lens.wlo  = (wc1 > wpw1) ? nbc_tick_t'(wc1 - wpw1) : nbc_tick_t'(1);
      lens.whi  = wpw1;
      lens.wext = extw1;
      lens.rsu  = rdy1;
      lens.rlo  = (rpw1 > acc1) ? rpw1 : acc1;
      lens.rhi  = hold1;
      lens.rtrn = extr1;
      lens.racc = acc1;
   end

endmodule

// File: rtl/nbc_cycle_fsm.sv
module nbc_cycle_fsm
   import nbc_pkg::*;
#(
   parameter int unsigned NUM_CS = 4,
   parameter int unsigned DQ_W   = 8,
   localparam int unsigned CS_W  = $clog2(NUM_CS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic            start_rd,
   input  nbc_kind_e       kind_i,
   input  logic [DQ_W-1:0] wbyte_i,
   input  logic [CS_W-1:0] cs_i,
   input  nbc_len_t        lens_i,
   input  logic [DQ_W-1:0] dq_in,
   output logic            busy,
   output logic            rd_done,
   output logic [DQ_W-1:0] rbyte,
   output logic [NUM_CS-1:0] ce_n,
   output logic            cle,
   output logic            ale,
   output logic            we_n,
   output logic            re_n,
   output logic [DQ_W-1:0] dq_out,
   output logic            dq_oe
);

   nbc_phase_e      ph, ph_nxt;
   nbc_tick_t       tk, ph_len;
   nbc_len_t        len_q;
   nbc_kind_e       kind_q;
   logic [CS_W-1:0] cs_q;
   logic [DQ_W-1:0] wbyte_q, rbyte_q;
   logic            ph_last, in_wr_strobe;

   always_comb begin
      ph_len = nbc_tick_t'(1);
      ph_nxt = NBC_PH_IDLE;
      unique case (ph)
         NBC_PH_WLO:  begin ph_len = len_q.wlo;  ph_nxt = NBC_PH_WHI;  end
         NBC_PH_WHI:  begin ph_len = len_q.whi;  ph_nxt = NBC_PH_WEXT; end
         NBC_PH_WEXT: begin ph_len = len_q.wext; ph_nxt = NBC_PH_IDLE; end
         NBC_PH_RSU:  begin ph_len = len_q.rsu;  ph_nxt = NBC_PH_RLO;  end
         NBC_PH_RLO:  begin ph_len = len_q.rlo;  ph_nxt = NBC_PH_RHI;  end
         NBC_PH_RHI:  begin ph_len = len_q.rhi;  ph_nxt = NBC_PH_RTRN; end
         NBC_PH_RTRN: begin ph_len = len_q.rtrn; ph_nxt = NBC_PH_IDLE; end
         default:     begin ph_len = nbc_tick_t'(1); ph_nxt = NBC_PH_IDLE; end
      endcase
   end

   assign ph_last = (tk == ph_len - nbc_tick_t'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph      <= NBC_PH_IDLE;
         tk      <= '0;
         len_q   <= '0;
         kind_q  <= NBC_K_CMD;
         cs_q    <= '0;
         wbyte_q <= '0;
         rbyte_q <= '0;
      end else if (ph == NBC_PH_IDLE) begin
         if (start) begin
            len_q   <= lens_i;
            kind_q  <= kind_i;
            cs_q    <= cs_i;
            wbyte_q <= wbyte_i;
            tk      <= '0;
            ph      <= start_rd ? NBC_PH_RSU : NBC_PH_WLO;
         end
      end else begin
         if (ph == NBC_PH_RLO && tk == len_q.racc - nbc_tick_t'(1))
            rbyte_q <= dq_in;
         if (ph_last) begin
            ph <= ph_nxt;
            tk <= '0;
         end else begin
            tk <= tk + nbc_tick_t'(1);
         end
      end
   end

   assign busy         = (ph != NBC_PH_IDLE);
   assign rd_done      = (ph == NBC_PH_RTRN) && ph_last;
   assign rbyte        = rbyte_q;
   assign in_wr_strobe = (ph == NBC_PH_WLO) || (ph == NBC_PH_WHI);
   assign cle          = in_wr_strobe && (kind_q == NBC_K_CMD);
   assign ale          = in_wr_strobe && (kind_q == NBC_K_ADR);
   assign we_n         = (ph != NBC_PH_WLO);
   assign re_n         = (ph != NBC_PH_RLO);
   assign dq_oe        = in_wr_strobe;
   assign dq_out       = wbyte_q;

   genvar g;
   generate
      for (g = 0; g < NUM_CS; g++) begin : g_ce
         assign ce_n[g] = !(busy && (cs_q == CS_W'(g)));
      end
   endgenerate

endmodule

// File: rtl/nbc_engine.sv
module nbc_engine
   import nbc_pkg::*;
#(
   parameter int unsigned NUM_CS      = 4,
   parameter int unsigned WIN_W       = 8,
   parameter int unsigned DQ_W        = 8,
   parameter int unsigned HRD_W       = 32,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned OFS_CMD     = 0,
   parameter int unsigned OFS_ADR     = 4,
   parameter int unsigned OFS_DAT     = 8,
   parameter int unsigned OFS_STAT    = 12,
   localparam int unsigned CS_W       = $clog2(NUM_CS),
   localparam int unsigned HA_W       = WIN_W + CS_W,
   localparam int unsigned TB_W       = NUM_CS * NBC_TREG_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              h_req,
   input  logic              h_wr,
   input  logic [HA_W-1:0]   h_addr,
   input  logic [DQ_W-1:0]   h_wdata,
   output logic              h_wait,
   output logic [HRD_W-1:0]  h_rdata,
   output logic              h_rvalid,
   input  logic [TB_W-1:0]   tim_wr_all,
   input  logic [TB_W-1:0]   tim_rd_all,
   output logic [NUM_CS-1:0] nf_ce_n,
   output logic              nf_cle,
   output logic              nf_ale,
   output logic              nf_we_n,
   output logic              nf_re_n,
   output logic [DQ_W-1:0]   nf_dq_out,
   output logic              nf_dq_oe,
   input  logic [DQ_W-1:0]   nf_dq_in,
   input  logic              nf_rb_n,
   output logic              flash_rdy
);

   generate
      if (NUM_CS < 2 || (NUM_CS & (NUM_CS - 1)) != 0) begin : g_bad_cs
         $error("nbc_engine: NUM_CS must be a power of two, at least 2");
      end
      if (HRD_W < DQ_W) begin : g_bad_hrd
         $error("nbc_engine: HRD_W must be at least DQ_W");
      end
      if (OFS_STAT >= (1 << WIN_W) || OFS_DAT >= (1 << WIN_W)) begin : g_bad_ofs
         $error("nbc_engine: port offsets must fit in the window");
      end
      if (OFS_CMD == OFS_ADR || OFS_CMD == OFS_DAT || OFS_ADR == OFS_DAT
          || OFS_STAT == OFS_CMD || OFS_STAT == OFS_ADR || OFS_STAT == OFS_DAT) begin : g_dup_ofs
         $error("nbc_engine: port offsets must be distinct");
      end
   endgenerate

   logic [WIN_W-1:0] ofs;
   logic [CS_W-1:0]  csel;
   logic             accept, hit_cmd, hit_adr, hit_dat, hit_stat;
   logic             go, quick_rd, busy, rd_done;
   nbc_kind_e        kind;
   nbc_len_t         lens;
   logic [DQ_W-1:0]  rbyte;

   assign ofs      = h_addr[WIN_W-1:0];
   assign csel     = h_addr[HA_W-1:WIN_W];
   assign accept   = h_req && !h_wait;
   assign hit_cmd  = (ofs == WIN_W'(OFS_CMD));
   assign hit_adr  = (ofs == WIN_W'(OFS_ADR));
   assign hit_dat  = (ofs == WIN_W'(OFS_DAT));
   assign hit_stat = (ofs == WIN_W'(OFS_STAT));
   assign go       = accept && (h_wr ? (hit_cmd || hit_adr || hit_dat) : hit_dat);
   assign quick_rd = accept && !h_wr && !hit_dat;

   always_comb begin
      if (hit_cmd)      kind = NBC_K_CMD;
      else if (hit_adr) kind = NBC_K_ADR;
      else              kind = NBC_K_DAT;
   end

   nbc_timing_sel #(.NUM_CS(NUM_CS)) u_tsel (
      .tim_wr_all (tim_wr_all),
      .tim_rd_all (tim_rd_all),
      .sel        (csel),
      .lens       (lens)
   );

   nbc_cycle_fsm #(.NUM_CS(NUM_CS), .DQ_W(DQ_W)) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (go),
      .start_rd (!h_wr),
      .kind_i   (kind),
      .wbyte_i  (h_wdata),
      .cs_i     (csel),
      .lens_i   (lens),
      .dq_in    (nf_dq_in),
      .busy     (busy),
      .rd_done  (rd_done),
      .rbyte    (rbyte),
      .ce_n     (nf_ce_n),
      .cle      (nf_cle),
      .ale      (nf_ale),
      .we_n     (nf_we_n),
      .re_n     (nf_re_n),
      .dq_out   (nf_dq_out),
      .dq_oe    (nf_dq_oe)
   );

   nbc_rdy_sync #(.STAGES(SYNC_STAGES)) u_rsync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (nf_rb_n),
      .sync_out (flash_rdy)
   );

   assign h_wait = busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         h_rvalid <= 1'b0;
         h_rdata  <= '0;
      end else if (quick_rd) begin
         h_rvalid <= 1'b1;
         h_rdata  <= hit_stat ? (HRD_W'(flash_rdy) << (HRD_W - 1)) : '0;
      end else if (rd_done) begin
         h_rvalid <= 1'b1;
         h_rdata  <= HRD_W'(rbyte);
      end else begin
         h_rvalid <= 1'b0;
      end
   end

endmodule

// File: rtl/nbc_engine_chk.sv
module nbc_engine_chk #(
   parameter int unsigned NUM_CS  = 4,
   parameter int unsigned WIN_W   = 8,
   parameter int unsigned OFS_CMD = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              h_req,
   input logic              h_wr,
   input logic [WIN_W-1:0]  h_ofs,
   input logic              h_wait,
   input logic              h_rvalid,
   input logic [NUM_CS-1:0] nf_ce_n,
   input logic              nf_cle,
   input logic              nf_ale,
   input logic              nf_we_n,
   input logic              nf_re_n,
   input logic              nf_dq_oe
);

   a_r12_one_target: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~nf_ce_n));

   a_r12_latch_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(nf_cle && nf_ale));

   a_r12_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
      nf_we_n || nf_re_n);

   a_r2_we_with_drive: assert property (@(posedge clk) disable iff (!rst_n)
      !nf_we_n |-> nf_dq_oe);

   a_r3_re_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
      !nf_re_n |-> !nf_dq_oe);

   a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !h_wait |-> ((&nf_ce_n) && nf_we_n && nf_re_n && !nf_dq_oe && !nf_cle && !nf_ale));

   a_r6_cmd_sets_wait: assert property (@(posedge clk) disable iff (!rst_n)
      (h_req && !h_wait && h_wr && h_ofs == WIN_W'(OFS_CMD)) |=> h_wait);

   a_r4_result_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      h_rvalid |-> !h_wait);

endmodule

bind nbc_engine nbc_engine_chk #(
   .NUM_CS  (NUM_CS),
   .WIN_W   (WIN_W),
   .OFS_CMD (OFS_CMD)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .h_req    (h_req),
   .h_wr     (h_wr),
   .h_ofs    (h_addr[WIN_W-1:0]),
   .h_wait   (h_wait),
   .h_rvalid (h_rvalid),
   .nf_ce_n  (nf_ce_n),
   .nf_cle   (nf_cle),
   .nf_ale   (nf_ale),
   .nf_we_n  (nf_we_n),
   .nf_re_n  (nf_re_n),
   .nf_dq_oe (nf_dq_oe)
);

// File: tb/nbc_engine_tb.sv
`timescale 1ns/1ps
module nbc_engine_tb;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         h_req = 1'b0, h_wr = 1'b0;
   logic [9:0]   h_addr = '0;
   logic [7:0]   h_wdata = '0;
   logic         h_wait, h_rvalid;
   logic [31:0]  h_rdata;
   logic [127:0] tim_wr_all = '0, tim_rd_all = '0;
   logic [3:0]   nf_ce_n;
   logic         nf_cle, nf_ale, nf_we_n, nf_re_n, nf_dq_oe, flash_rdy;
   logic [7:0]   nf_dq_out;
   logic [7:0]   nf_dq_in = '0;
   logic         nf_rb_n = 1'b0;

   always #2.5 clk = ~clk;

   nbc_engine u_dut (
      .clk(clk), .rst_n(rst_n), .h_req(h_req), .h_wr(h_wr), .h_addr(h_addr),
      .h_wdata(h_wdata), .h_wait(h_wait), .h_rdata(h_rdata), .h_rvalid(h_rvalid),
      .tim_wr_all(tim_wr_all), .tim_rd_all(tim_rd_all), .nf_ce_n(nf_ce_n),
      .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we_n(nf_we_n), .nf_re_n(nf_re_n),
      .nf_dq_out(nf_dq_out), .nf_dq_oe(nf_dq_oe), .nf_dq_in(nf_dq_in),
      .nf_rb_n(nf_rb_n), .flash_rdy(flash_rdy)
   );

   typedef struct packed {
      logic [3:0]  ce_n;
      logic        cle, ale, we_n, re_n, oe;
      logic [7:0]  dout;
      logic        wt, rv;
      logic [31:0] rdata;
   } vec_t;

   typedef struct {
      logic       wr;
      logic [9:0] a;
      logic [7:0] d;
   } op_t;

   localparam vec_t IDLE_V = '{ce_n: 4'hF, cle: 1'b0, ale: 1'b0, we_n: 1'b1,
                               re_n: 1'b1, oe: 1'b0, dout: 8'h00, wt: 1'b0,
                               rv: 1'b0, rdata: 32'h0};

   vec_t  exp_q[$];
   string tag_q[$];
   op_t   ops[$];
   string cur_tag = "R11";

   int t_rdy[4], t_extw[4], t_wc[4], t_wpw[4];
   int t_acc[4], t_hold[4], t_rpw[4], t_extr[4];

   int vectors = 0, miscompares = 0;
   int re_cnt = 0, fl_acc = 1, rd_seq = 0;
   logic [7:0] fl_byte = 8'h00;
   logic [7:0] lfsr = 8'hA7;
   logic rb_run = 1'b0, d1 = 1'b0, d2 = 1'b0, rdy_now = 1'b0;
   logic done = 1'b0;

   function automatic int m1(input int x);
      return (x == 0) ? 1 : x;
   endfunction

   task automatic set_tim(input int cs, input int rdy, input int extw, input int wc, input int wpw,
                          input int acc, input int hold, input int rpw, input int extr);
      t_rdy[cs] = rdy; t_extw[cs] = extw; t_wc[cs] = wc; t_wpw[cs] = wpw;
      t_acc[cs] = acc; t_hold[cs] = hold; t_rpw[cs] = rpw; t_extr[cs] = extr;
      // R10: word A = {rdy, extw, wc, wpw}, word B = {acc, hold, rpw, extr}
      tim_wr_all[cs*32 +: 32] = {8'(rdy), 8'(extw), 8'(wc), 8'(wpw)};
      tim_rd_all[cs*32 +: 32] = {8'(acc), 8'(hold), 8'(rpw), 8'(extr)};
   endtask

   task automatic push(input vec_t v, input int n);
      for (int i = 0; i < n; i++) begin
         exp_q.push_back(v);
         tag_q.push_back(cur_tag);
      end
   endtask

   task automatic gen(input op_t op);
      int         cs;
      logic [7:0] o;
      vec_t       v;
      int         wc, wp, lo;
      cs = int'(op.a[9:8]);
      o  = op.a[7:0];
      v  = IDLE_V;
      v.ce_n = ~(4'b0001 << cs);
      v.wt   = 1'b1;
      if (op.wr) begin
         if (o == 8'h00 || o == 8'h04 || o == 8'h08) begin
            wc = m1(t_wc[cs]); wp = m1(t_wpw[cs]);
            lo = (wc > wp) ? wc - wp : 1;
            v.cle = (o == 8'h00); v.ale = (o == 8'h04);
            v.oe = 1'b1; v.dout = op.d;
            v.we_n = 1'b0; push(v, lo);
            v.we_n = 1'b1; push(v, wp);
            v.cle = 1'b0; v.ale = 1'b0; v.oe = 1'b0;
            push(v, m1(t_extw[cs]));
         end
      end else if (o == 8'h08) begin
         rd_seq++;
         fl_byte = 8'h3C + 8'(rd_seq * 37);
         fl_acc  = m1(t_acc[cs]);
         push(v, m1(t_rdy[cs]));
         v.re_n = 1'b0;
         push(v, (m1(t_rpw[cs]) > fl_acc) ? m1(t_rpw[cs]) : fl_acc);
         v.re_n = 1'b1;
         push(v, m1(t_hold[cs]));
         push(v, m1(t_extr[cs]));
         v = IDLE_V; v.rv = 1'b1; v.rdata = {24'h0, fl_byte};
         push(v, 1);
      end else begin
         v = IDLE_V; v.rv = 1'b1;
         v.rdata = (o == 8'h0C) ? {rdy_now, 31'h0} : 32'h0;
         push(v, 1);
      end
   endtask

   task automatic add_op(input logic wr, input logic [1:0] cs, input logic [7:0] o, input logic [7:0] d);
      op_t op;
      op.wr = wr; op.a = {cs, o}; op.d = d;
      ops.push_back(op);
   endtask

   task automatic step();
      vec_t  cur, act;
      string tg;
      logic  nb;
      @(negedge clk);
      if (exp_q.size() > 0) begin
         cur = exp_q.pop_front();
         tg  = tag_q.pop_front();
      end else begin
         cur = IDLE_V;
         tg  = "R11 R6 idle";
      end
      act = '{ce_n: nf_ce_n, cle: nf_cle, ale: nf_ale, we_n: nf_we_n, re_n: nf_re_n,
              oe: nf_dq_oe, dout: nf_dq_out, wt: h_wait, rv: h_rvalid, rdata: h_rdata};
      if (!cur.oe) act.dout  = cur.dout;
      if (!cur.rv) act.rdata = cur.rdata;
      vectors++;
      if (act !== cur) begin
         miscompares++;
         $display("FAIL %s @%0t: actual %h expected %h", tg, $time, act, cur);
      end
      vectors++;
      if (flash_rdy !== d2) begin
         miscompares++;
         $display("FAIL R8 @%0t: flash_rdy actual %b expected %b", $time, flash_rdy, d2);
      end
      rdy_now = d2;
      // flash data model: the real byte is present only during tick fl_acc of RE# low
      if (!nf_re_n) re_cnt++; else re_cnt = 0;
      nf_dq_in = (re_cnt == fl_acc) ? fl_byte : ~fl_byte;
      // ready/busy wander
      if (rb_run) begin
         lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
         nb = lfsr[0];
      end else begin
         nb = 1'b0;
      end
      nf_rb_n = nb;
      d2 = d1; d1 = nb;
      // host stimulus: hold the request until it is accepted (R6)
      if (ops.size() > 0) begin
         h_req = 1'b1; h_wr = ops[0].wr; h_addr = ops[0].a; h_wdata = ops[0].d;
         if (!cur.wt) begin
            gen(ops[0]);
            void'(ops.pop_front());
         end
      end else begin
         h_req = 1'b0;
      end
   endtask

   task automatic drain();
      while (ops.size() > 0 || exp_q.size() > 0) step();
      repeat (3) step();
   endtask

   initial begin
      repeat (40000) @(posedge clk);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog: run did not finish, pending ops %0d expected 0", ops.size());
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      set_tim(0, 2, 3, 5, 2, 3, 2, 4, 2);
      set_tim(1, 1, 1, 3, 1, 1, 1, 2, 1);
      set_tim(2, 4, 2, 3, 4, 5, 3, 2, 3);
      set_tim(3, 0, 0, 0, 0, 0, 0, 0, 0);

      // R11: reset state, R8 ready held at 0 in reset
      cur_tag = "R11";
      repeat (4) step();
      rst_n  = 1'b1;
      rb_run = 1'b1;
      repeat (3) step();

      // R1 R2 R6: command, three ordered address bytes, data write
      cur_tag = "R1 R2 R6";
      add_op(1'b1, 2'd0, 8'h00, 8'h70);
      add_op(1'b1, 2'd0, 8'h04, 8'h11);
      add_op(1'b1, 2'd0, 8'h04, 8'h22);
      add_op(1'b1, 2'd0, 8'h04, 8'h33);
      add_op(1'b1, 2'd1, 8'h08, 8'hA5);
      drain();

      // R3 R4: data reads on two targets, back to back
      cur_tag = "R3 R4";
      add_op(1'b0, 2'd0, 8'h08, 8'h00);
      add_op(1'b0, 2'd1, 8'h08, 8'h00);
      add_op(1'b1, 2'd1, 8'h00, 8'hFF);
      drain();

      // R5: wpw above wc saturates, access beyond pulse, all-zero target
      cur_tag = "R5 R3 R4";
      add_op(1'b1, 2'd2, 8'h00, 8'h90);
      add_op(1'b0, 2'd2, 8'h08, 8'h00);
      add_op(1'b1, 2'd3, 8'h04, 8'h5E);
      add_op(1'b0, 2'd3, 8'h08, 8'h00);
      drain();

      // R7 R8: status reads, back to back, while ready wanders
      cur_tag = "R7 R8";
      for (int i = 0; i < 8; i++) add_op(1'b0, 2'(i), 8'h0C, 8'h00);
      add_op(1'b1, 2'd0, 8'h08, 8'h42);
      add_op(1'b0, 2'd2, 8'h0C, 8'h00);
      drain();

      // R9: unmapped writes ignored, unmapped reads return zero
      cur_tag = "R9";
      add_op(1'b1, 2'd0, 8'h10, 8'hEE);
      add_op(1'b1, 2'd1, 8'h0C, 8'hEE);
      add_op(1'b0, 2'd2, 8'h20, 8'h00);
      add_op(1'b0, 2'd3, 8'h00, 8'h00);
      add_op(1'b1, 2'd2, 8'h05, 8'hEE);
      add_op(1'b1, 2'd1, 8'h04, 8'h0F);
      drain();

      // R10: new timing for target 1 only; target 0 keeps its own
      cur_tag = "R10";
      set_tim(1, 3, 2, 7, 3, 2, 2, 3, 4);
      add_op(1'b1, 2'd1, 8'h00, 8'h60);
      add_op(1'b0, 2'd1, 8'h08, 8'h00);
      add_op(1'b1, 2'd0, 8'h04, 8'hC3);
      add_op(1'b0, 2'd0, 8'h08, 8'h00);
      drain();

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule